// File: doc/BRIEF.md
# Indirect Command-Port Register Sequencer

This block sits on the host side of an 8-bit asynchronous command port belonging to a USB peripheral controller. The controller exposes its internal registers only indirectly: the host first writes a command word naming the register and the direction of the access, and the data transfer follows on the same port. The sequencer turns a simple one-shot request into that chain of strobed bus cycles. The request carries a register number, a direction flag and a write byte. On completion, the block returns a one-cycle done pulse and, for reads, the register value.

A register write becomes three strobed writes. The first carries the address word. The second carries a data word holding the high nibble, and the third a data word holding the low nibble. A register read becomes one address-word write followed by a single read strobe, which captures the byte. Before every strobe the block waits for the device's READY line. If READY stays low for too long, the sequence is abandoned with a timeout pulse.

The device data bus is split into an output byte with an output-enable and a separate input byte. An outer pad or tristate buffer can then merge them.

Top module: `cmd_port_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, chip select, read strobe and write strobe are all high (inactive), the data output-enable is low, and neither the done nor the timeout pulse is high.
- R2: Whenever chip select is low, the 3-bit FIFO address output equals binary 100, which selects the command port.
- R3: A write request to register A with byte D produces exactly three write strobes. Their data bytes are, in order: the address word {1'b1, 1'b0, A[5:0]}, then {4'b0000, D[7:4]}, then {4'b0000, D[3:0]}.
- R4: A read request to register A produces one write strobe carrying {1'b1, 1'b1, A[5:0]}, followed by one read strobe. The byte on the device input at the last cycle of that read strobe is returned on the read-data output.
- R5: A strobe begins only on the cycle after READY was sampled high. While READY is held low below the timeout limit, no strobe starts, and the access completes once READY rises.
- R6: Every strobe stays low for exactly STROBE_CYC clock cycles. At least one cycle with both strobes and chip select high separates any two strobes.
- R7: Done is high for exactly one cycle after the final strobe of a sequence. The read-data output keeps its value until the next read completes.
- R8: A request presented while a sequence is in progress is ignored. It causes no extra strobes and changes no register.
- R9: If READY stays low for TIMEOUT_CYC consecutive cycles while a strobe is awaited, the timeout output pulses for one cycle instead of done. No strobe is issued, and the block returns to idle and accepts the next request.
- R10: Read and write strobes are never low together. The data output-enable is high during write strobes and low during read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_sub | input | SUB_W | Register subaddress |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | One-cycle READY timeout pulse |
| rsp_rdata | output | 8 | Last register value read |
| dev_fifo_addr | output | 3 | Device FIFO/port select |
| dev_cs_n | output | 1 | Device chip select, active low |
| dev_rd_n | output | 1 | Device read strobe, active low |
| dev_wr_n | output | 1 | Device write strobe, active low |
| dev_data_out | output | 8 | Command word driven to the device |
| dev_data_oe | output | 1 | Enable for dev_data_out onto the bus |
| dev_data_in | input | 8 | Byte returned by the device |
| dev_ready | input | 1 | Device ready for the next access |

## Verification
A wrong step counter or step decode shows up within the same access as a misordered or missing command word. For example, a nibble may arrive before the address word, or a read may be missing its read strobe; the device model then stores the wrong byte, and the following read-back exposes it. A wrong strobe-timer count is seen at the very next strobe, as a low period of the wrong length. A wrong READY-wait counter is seen as a timeout pulse arriving in the wrong cycle, or a strobe starting while READY is low. A state machine that leaves idle on a request it should ignore produces surplus strobes before the current done pulse.

// File: rtl/cps_pkg.sv
package cps_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_STRB = 2'd2,
      ST_GAP  = 2'd3
   } cps_state_e;

   localparam int CPS_WORD_W = 8;
   localparam int CPS_NIB_W  = 4;
   localparam int CPS_SUB_W  = 6;

   function automatic logic [CPS_WORD_W-1:0] cps_addr_word(input logic rd,
                                                           input logic [CPS_SUB_W-1:0] sub);
      return {1'b1, rd, sub};
   endfunction

   function automatic logic [CPS_WORD_W-1:0] cps_nib_word(input logic [CPS_NIB_W-1:0] nib);
      return {{(CPS_WORD_W-CPS_NIB_W){1'b0}}, nib};
   endfunction

endpackage

// File: rtl/cps_step_plan.sv
module cps_step_plan #(
   parameter int SUB_W = 6
) (
   input  logic             op_write,
   input  logic [1:0]       step,
   input  logic [SUB_W-1:0] sub,
   input  logic [7:0]       wdata,
   output logic [7:0]       word,
   output logic             is_read,
   output logic             is_last
);
   import cps_pkg::*;

   generate
      if (SUB_W != CPS_SUB_W) begin : g_bad_sub
         $error("cps_step_plan: SUB_W must match the 6-bit address field");
      end
   endgenerate

   always_comb begin
      word    = '0;
      is_read = 1'b0;
      is_last = 1'b0;
      if (op_write) begin
         case (step)
            2'd0: word = cps_addr_word(1'b0, sub);
            2'd1: word = cps_nib_word(wdata[7:4]);
            2'd2: begin
               word    = cps_nib_word(wdata[3:0]);
               is_last = 1'b1;
            end
            default: is_last = 1'b1;
         endcase
      end else begin
         case (step)
            2'd0: word = cps_addr_word(1'b1, sub);
            default: begin
               is_read = 1'b1;
               is_last = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/cps_strobe_timer.sv
module cps_strobe_timer #(
   parameter int CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic last
);
   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("cps_strobe_timer: CYC must be at least 1");
      end else if (CYC == 1) begin : g_single
         assign last = active;
      end else begin : g_count
         localparam int CW = $clog2(CYC);
         localparam logic [CW-1:0] LAST_V = CW'(CYC - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!active || last) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign last = active && (cnt_q == LAST_V);
      end
   endgenerate

endmodule

// File: rtl/cps_ready_timer.sv
module cps_ready_timer #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic ready,
   output logic expired
);
   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("cps_ready_timer: LIMIT must be at least 2");
      end
   endgenerate

   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!arm || ready || expired) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = arm && !ready && (cnt_q == LAST_V);

endmodule

// File: rtl/cmd_port_seq.sv
module cmd_port_seq #(
   parameter int         SUB_W       = 6,
   parameter int         MIN_REGS    = 37,
   parameter int         STROBE_CYC  = 2,
   parameter int         TIMEOUT_CYC = 64,
   parameter logic [2:0] CMD_SEL     = 3'b100,
   parameter logic [2:0] PARK_SEL    = 3'b000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [SUB_W-1:0] req_sub,
   input  logic [7:0]       req_wdata,
   output logic             rsp_done,
   output logic             rsp_timeout,
   output logic [7:0]       rsp_rdata,
   output logic [2:0]       dev_fifo_addr,
   output logic             dev_cs_n,
   output logic             dev_rd_n,
   output logic             dev_wr_n,
   output logic [7:0]       dev_data_out,
   output logic             dev_data_oe,
   input  logic [7:0]       dev_data_in,
   input  logic             dev_ready
);
   import cps_pkg::*;

   generate
      if ((2 ** SUB_W) < MIN_REGS) begin : g_bad_range
         $error("cmd_port_seq: SUB_W too narrow for MIN_REGS registers");
      end
      if (CMD_SEL == PARK_SEL) begin : g_bad_sel
         $error("cmd_port_seq: PARK_SEL must differ from CMD_SEL");
      end
   endgenerate

   cps_state_e       state_q;
   logic             op_wr_q;
   logic [SUB_W-1:0] sub_q;
   logic [7:0]       wdata_q;
   logic [1:0]       step_q;
   logic [7:0]       rdata_q;
   logic             done_q;
   logic             tmo_q;

   logic [7:0]       step_word;
   logic             step_is_read;
   logic             step_is_last;
   logic             in_wait;
   logic             in_strb;
   logic             strb_last;
   logic             rdy_expired;

   assign in_wait = (state_q == ST_WAIT);
   assign in_strb = (state_q == ST_STRB);

   cps_step_plan #(.SUB_W(SUB_W)) u_plan (
      .op_write (op_wr_q),
      .step     (step_q),
      .sub      (sub_q),
      .wdata    (wdata_q),
      .word     (step_word),
      .is_read  (step_is_read),
      .is_last  (step_is_last)
   );

   cps_strobe_timer #(.CYC(STROBE_CYC)) u_strb (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (in_strb),
      .last   (strb_last)
   );

   cps_ready_timer #(.LIMIT(TIMEOUT_CYC)) u_rdy (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (in_wait),
      .ready   (dev_ready),
      .expired (rdy_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_wr_q <= 1'b0;
         sub_q   <= '0;
         wdata_q <= '0;
         step_q  <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         tmo_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  op_wr_q <= req_write;
                  sub_q   <= req_sub;
                  wdata_q <= req_wdata;
                  step_q  <= '0;
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (dev_ready) begin
                  state_q <= ST_STRB;
               end else if (rdy_expired) begin
                  tmo_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_STRB: begin
               if (strb_last) begin
                  if (step_is_read) begin
                     rdata_q <= dev_data_in;
                  end
                  state_q <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (step_is_last) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  step_q  <= step_q + 1'b1;
                  state_q <= ST_WAIT;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign dev_fifo_addr = (state_q == ST_IDLE) ? PARK_SEL : CMD_SEL;
   assign dev_cs_n      = !in_strb;
   assign dev_wr_n      = !(in_strb && !step_is_read);
   assign dev_rd_n      = !(in_strb && step_is_read);
   assign dev_data_oe   = in_strb && !step_is_read;
   assign dev_data_out  = step_word;

   assign rsp_done    = done_q;
   assign rsp_timeout = tmo_q;
   assign rsp_rdata   = rdata_q;

endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
   parameter int         STROBE_CYC = 2,
   parameter logic [2:0] CMD_SEL    = 3'b100
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] dev_fifo_addr,
   input logic       dev_cs_n,
   input logic       dev_rd_n,
   input logic       dev_wr_n,
   input logic       dev_data_oe,
   input logic       dev_ready,
   input logic       rsp_done,
   input logic       rsp_timeout
);
   logic strb_idle;
   int   low_cnt;

   assign strb_idle = dev_wr_n && dev_rd_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= 0;
      end else if (!strb_idle) begin
         low_cnt <= low_cnt + 1;
      end else begin
         low_cnt <= 0;
      end
   end

   assert_cmd_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_cs_n |-> dev_fifo_addr == CMD_SEL);

   assert_ready_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dev_wr_n) || $fell(dev_rd_n)) |-> $past(dev_ready));

   assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_idle) |-> low_cnt == STROBE_CYC);

   assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_idle) |=> strb_idle && dev_cs_n);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_end_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_done && rsp_timeout));

   assert_timeout_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_timeout |-> !$past(dev_ready) && dev_cs_n);

   assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dev_wr_n && !dev_rd_n));

   assert_bus_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_rd_n |-> !dev_data_oe);

endmodule

bind cmd_port_seq cps_checker #(
   .STROBE_CYC (STROBE_CYC),
   .CMD_SEL    (CMD_SEL)
) u_cps_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .dev_fifo_addr (dev_fifo_addr),
   .dev_cs_n      (dev_cs_n),
   .dev_rd_n      (dev_rd_n),
   .dev_wr_n      (dev_wr_n),
   .dev_data_oe   (dev_data_oe),
   .dev_ready     (dev_ready),
   .rsp_done      (rsp_done),
   .rsp_timeout   (rsp_timeout)
);

// File: tb/tb_cmd_port_seq.sv
module tb_cmd_port_seq;
   localparam int S = 3;
   localparam int L = 40;
   localparam int NV = 8;
   localparam logic [13:0] VEC [NV] = '{
      {6'h00, 8'hA5}, {6'h3F, 8'h5A}, {6'h24, 8'hFF}, {6'h01, 8'h00},
      {6'h12, 8'h3C}, {6'h2A, 8'hC3}, {6'h07, 8'h81}, {6'h30, 8'h7E}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [5:0] req_sub = '0;
   logic [7:0] req_wdata = '0;
   logic       rsp_done, rsp_timeout;
   logic [7:0] rsp_rdata;
   logic [2:0] dev_fifo_addr;
   logic       dev_cs_n, dev_rd_n, dev_wr_n, dev_data_oe, dev_ready;
   logic [7:0] dev_data_out, dev_data_in;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   cmd_port_seq #(.STROBE_CYC(S), .TIMEOUT_CYC(L)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_sub(req_sub), .req_wdata(req_wdata), .rsp_done(rsp_done),
      .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
      .dev_fifo_addr(dev_fifo_addr), .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n),
      .dev_wr_n(dev_wr_n), .dev_data_out(dev_data_out), .dev_data_oe(dev_data_oe),
      .dev_data_in(dev_data_in), .dev_ready(dev_ready)
   );

   // device model
   logic [7:0] mreg [64];
   logic [5:0] ptr = '0;
   logic       nib_ph = 1'b0;
   logic [3:0] hi_nib = '0;
   logic [7:0] wlog [3];
   int         wcount = 0, rcount = 0;
   int         low_run = 0, high_run = 100, last_width = 0, min_gap = 100;
   bit         bad_sel = 0, bad_oe = 0;
   int         dly = 2;
   bit         stall = 0;
   int         hold = 0;
   logic       wr_prev = 1'b1, rd_prev = 1'b1;

   initial for (int i = 0; i < 64; i++) mreg[i] = 8'h00;

   assign dev_ready   = !stall && (hold == 0);
   assign dev_data_in = mreg[ptr];

   always @(posedge clk) begin
      wr_prev <= dev_wr_n;
      rd_prev <= dev_rd_n;
      if (!dev_wr_n || !dev_rd_n) begin
         if (dev_fifo_addr != 3'b100 || dev_cs_n) bad_sel = 1;
         if (!dev_wr_n && !dev_data_oe) bad_oe = 1;
         if (!dev_rd_n && dev_data_oe) bad_oe = 1;
      end
      if (!dev_wr_n && wr_prev) begin
         wlog[0] = wlog[1]; wlog[1] = wlog[2]; wlog[2] = dev_data_out;
         wcount++;
         if (dev_data_out[7]) begin
            ptr = dev_data_out[5:0];
            nib_ph = 0;
         end else if (!nib_ph) begin
            hi_nib = dev_data_out[3:0];
            nib_ph = 1;
         end else begin
            mreg[ptr] = {hi_nib, dev_data_out[3:0]};
            nib_ph = 0;
         end
      end
      if (!dev_rd_n && rd_prev) rcount++;
      if ((!dev_wr_n && wr_prev) || (!dev_rd_n && rd_prev)) begin
         hold <= dly;
         if (high_run < min_gap) min_gap = high_run;
      end else if (hold > 0) hold <= hold - 1;
      if (!dev_wr_n || !dev_rd_n) begin
         low_run++;
         high_run = 0;
      end else begin
         if (low_run != 0) last_width = low_run;
         low_run = 0;
         high_run++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_req(input bit w, input logic [5:0] a, input logic [7:0] d,
                         output bit gd, output bit gt, output int n);
      req_valid = 1; req_write = w; req_sub = a; req_wdata = d;
      gd = 0; gt = 0; n = 0;
      while (!gd && !gt && n < 400) begin
         @(negedge clk);
         n++;
         if (n == 1) req_valid = 0;
         gd = rsp_done;
         gt = rsp_timeout;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         tests++; fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      bit gd, gt;
      int n, w0;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(dev_cs_n && dev_wr_n && dev_rd_n && !dev_data_oe && !rsp_done && !rsp_timeout,
          "R1 outputs in reset", {dev_cs_n, dev_wr_n, dev_rd_n, dev_data_oe}, 4'b1110);
      rst_n = 1;
      @(negedge clk);
      chk(dev_cs_n && dev_wr_n && dev_rd_n && !rsp_done, "R1 after reset",
          {dev_cs_n, dev_wr_n, dev_rd_n}, 3'b111);

      // vector table: writes, then reads back
      for (int i = 0; i < NV; i++) begin
         w0 = wcount;
         do_req(1, VEC[i][13:8], VEC[i][7:0], gd, gt, n);
         chk(gd && !gt, "R3 write done", {gd, gt}, 2'b10);
         chk(wcount - w0 == 3, "R3 write strobe count", wcount - w0, 3);
         chk(wlog[0] == {2'b10, VEC[i][13:8]} && wlog[1] == {4'h0, VEC[i][7:4]}
             && wlog[2] == {4'h0, VEC[i][3:0]}, "R3 word order",
             {wlog[0], wlog[1], wlog[2]}, {2'b10, VEC[i][13:8], 4'h0, VEC[i][7:4], 4'h0, VEC[i][3:0]});
         @(negedge clk);
         chk(!rsp_done, "R7 done single cycle", rsp_done, 0);
      end
      for (int i = 0; i < NV; i++) begin
         w0 = rcount;
         do_req(0, VEC[i][13:8], 8'h00, gd, gt, n);
         chk(gd && rsp_rdata == VEC[i][7:0], "R4 read value", rsp_rdata, VEC[i][7:0]);
         chk(wlog[2] == {2'b11, VEC[i][13:8]} && rcount - w0 == 1, "R4 read command",
             wlog[2], {2'b11, VEC[i][13:8]});
      end
      chk(last_width == S, "R6 strobe width", last_width, S);
      chk(min_gap >= 1, "R6 idle between strobes", min_gap, 1);
      chk(!bad_sel, "R2 command port select", bad_sel, 0);
      chk(!bad_oe, "R10 bus direction", bad_oe, 0);

      // R7: read data held across a write
      held = rsp_rdata;
      do_req(1, 6'h02, 8'h11, gd, gt, n);
      chk(rsp_rdata == held, "R7 rdata held", rsp_rdata, held);

      // R5: READY low below limit delays strobes
      stall = 1;
      w0 = wcount;
      req_valid = 1; req_write = 1; req_sub = 6'h05; req_wdata = 8'h96;
      @(negedge clk); req_valid = 0;
      repeat (20) @(negedge clk);
      chk(wcount == w0, "R5 no strobe while not ready", wcount - w0, 0);
      stall = 0;
      gd = 0; n = 0;
      while (!gd && n < 400) begin @(negedge clk); n++; gd = rsp_done; end
      chk(gd && wcount - w0 == 3, "R5 completes after ready", wcount - w0, 3);
      do_req(0, 6'h05, 8'h00, gd, gt, n);
      chk(rsp_rdata == 8'h96, "R5 stalled write value", rsp_rdata, 8'h96);

      // R8: request while busy ignored
      dly = 12;
      w0 = wcount;
      req_valid = 1; req_write = 1; req_sub = 6'h10; req_wdata = 8'h99;
      @(negedge clk); req_valid = 0;
      repeat (3) @(negedge clk);
      req_valid = 1; req_write = 1; req_sub = 6'h11; req_wdata = 8'h44;
      @(negedge clk); req_valid = 0;
      gd = 0; n = 0;
      while (!gd && n < 400) begin @(negedge clk); n++; gd = rsp_done; end
      repeat (3) @(negedge clk);
      chk(wcount - w0 == 3, "R8 no extra strobes", wcount - w0, 3);
      dly = 2;
      do_req(0, 6'h11, 8'h00, gd, gt, n);
      chk(rsp_rdata == 8'h00, "R8 ignored register untouched", rsp_rdata, 8'h00);
      do_req(0, 6'h10, 8'h00, gd, gt, n);
      chk(rsp_rdata == 8'h99, "R8 accepted write landed", rsp_rdata, 8'h99);

      // R9: timeout
      stall = 1;
      w0 = wcount;
      do_req(1, 6'h08, 8'h55, gd, gt, n);
      chk(gt && !gd, "R9 timeout pulse", {gd, gt}, 2'b01);
      chk(n == L + 1, "R9 timeout latency", n, L + 1);
      chk(wcount == w0, "R9 no strobe on timeout", wcount - w0, 0);
      @(negedge clk);
      chk(!rsp_timeout, "R9 timeout single cycle", rsp_timeout, 0);
      stall = 0;
      do_req(0, 6'h24, 8'h00, gd, gt, n);
      chk(gd && rsp_rdata == 8'hFF, "R9 idle after timeout", rsp_rdata, 8'hFF);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule